// File: doc/BRIEF.md
# Speculative Load Alias Tracker

This block lets a scheduler hoist a load above stores that may write the same memory location. When a load is issued early, it records its destination register number and memory address in a small fully associative table. Every later store searches all entries at once by address and clears any entry it matches. Before the hoisted value is used, a check on the destination register looks in the table. If the register still has a live entry, the check reports success. If the entry was cleared or was never there, the check reports failure, and the surrounding pipeline then redirects to recovery code. That recovery code and the data path are outside this block.

Addresses are compared at a block granularity of 2^GRAN_LOG2 bytes, which is 8 bytes by default. The table keeps at most one live entry per register. When a new entry is needed it goes into a free slot if one exists. When the table is full, slots are reclaimed in round-robin order. A check result comes out of a register one cycle after its request. The lookup uses the table contents as they stood before that cycle's insert and store.

Top module: `spec_load_tracker`

## Requirements
- R1: After synchronous reset every slot is empty and `res_valid` is low. Each check made after reset, before any insert, reports `res_ok` = 0.
- R2: A check request in cycle n produces `res_valid` = 1 in cycle n+1 with the lookup outcome on `res_ok`. `res_valid` is 0 in the cycle after a cycle with no request. A check on a register that has a live entry reports `res_ok` = 1.
- R3: A check on a register that has no live entry reports `res_ok` = 0.
- R4: A store clears every live entry whose address agrees with the store address in bits [ADDR_W-1:GRAN_LOG2]. Differences in the low GRAN_LOG2 bits are ignored. Entries in other address blocks stay live.
- R5: A single store clears all matching entries at once, even when they belong to different registers.
- R6: An insert for a register that already has a live entry overwrites that entry. After the overwrite, only the new address is tracked, and no other slot is disturbed, even when the table is full.
- R7: While free slots remain, an insert takes the lowest-numbered free slot and leaves all live entries intact. ENTRIES distinct registers can therefore all be live together.
- R8: When all slots are live and the inserted register has no entry, the insert overwrites the slot named by a round-robin pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, after each such eviction.
- R9: A check does not modify the table. Repeated checks give the same answer, and a failed check creates no entry.
- R10: When an insert and a store to the same address block happen in the same cycle, the inserted entry ends up live.
- R11: A check made in the same cycle as an insert or store sees the table as it was before that cycle's update.
- R12: A slot cleared by a store counts as free. A later insert reuses it in preference to evicting a live entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Record a hoisted load this cycle |
| ins_reg | input | REG_W | Destination register of the hoisted load |
| ins_addr | input | ADDR_W | Byte address of the hoisted load |
| st_valid | input | 1 | A store is snooped this cycle |
| st_addr | input | ADDR_W | Byte address of the store |
| chk_valid | input | 1 | Check request this cycle |
| chk_reg | input | REG_W | Register whose hoisted value is being validated |
| res_valid | output | 1 | Check result present (one cycle after request) |
| res_ok | output | 1 | 1 = speculative value still good, 0 = recovery required |

## Verification
The bench fills the table with one register per slot and probes every register after each event. A wrong granularity mask would either miss stores that fall within the same 8-byte block or clear neighbouring blocks. A victim selector that ignores freed slots would evict a live load when it should reuse a cleared slot. A round-robin pointer that starts wrong or fails to advance would clear the wrong register on the second eviction. An overwrite that allocated a new slot instead of reusing the old one would leave the old address still tracked, and on a full table it would evict an unrelated entry. Same-cycle cases are also checked: insert together with store, and check together with insert or store. These catch a store that wins over an insert, or a lookup that sees the update from its own cycle.

// File: rtl/slt_pkg.sv
package slt_pkg;

  // How the slot for an incoming hoisted load was chosen.
  typedef enum logic [1:0] {
    PICK_REG   = 2'd0,  // register already owns a live slot
    PICK_FREE  = 2'd1,  // lowest empty slot
    PICK_EVICT = 2'd2   // table full, round-robin victim
  } pick_e;

endpackage

// File: rtl/slt_match.sv
// Parallel comparators for all slots: store block address, insert register,
// check register. Only live slots can match.
module slt_match #(
  parameter int ENTRIES = 16,
  parameter int REG_W   = 7,
  parameter int TAG_W   = 29
) (
  input  logic [ENTRIES-1:0]            valid_q,
  input  logic [ENTRIES-1:0][REG_W-1:0] reg_q,
  input  logic [ENTRIES-1:0][TAG_W-1:0] tag_q,
  input  logic [TAG_W-1:0]              st_tag,
  input  logic [REG_W-1:0]              ins_reg,
  input  logic [REG_W-1:0]              chk_reg,
  output logic [ENTRIES-1:0]            st_hit,
  output logic [ENTRIES-1:0]            ins_hit,
  output logic [ENTRIES-1:0]            chk_hit
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign st_hit[g]  = valid_q[g] && (tag_q[g] == st_tag);
    assign ins_hit[g] = valid_q[g] && (reg_q[g] == ins_reg);
    assign chk_hit[g] = valid_q[g] && (reg_q[g] == chk_reg);
  end

endmodule

// File: rtl/slt_victim.sv
// Chooses the slot an insert writes: the register's own slot, else the
// lowest free slot, else the round-robin pointer (which then advances).
module slt_victim
  import slt_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ins_valid,
  input  logic [ENTRIES-1:0] valid_q,
  input  logic [ENTRIES-1:0] ins_hit,
  output logic [IDX_W-1:0]   slot,
  output pick_e              pick
);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] hit_idx;
  logic             free_any;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ins_hit[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end

  always_comb begin
    if (|ins_hit) begin
      pick = PICK_REG;
      slot = hit_idx;
    end else if (free_any) begin
      pick = PICK_FREE;
      slot = free_idx;
    end else begin
      pick = PICK_EVICT;
      slot = rr_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (ins_valid && pick == PICK_EVICT) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

endmodule

// File: rtl/slt_array.sv
// Slot storage. Live bits reset; register and tag fields do not.
// An insert to a slot takes precedence over a store clearing it.
module slt_array #(
  parameter int ENTRIES = 16,
  parameter int REG_W   = 7,
  parameter int TAG_W   = 29,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ins_valid,
  input  logic [IDX_W-1:0]              ins_slot,
  input  logic [REG_W-1:0]              ins_reg,
  input  logic [TAG_W-1:0]              ins_tag,
  input  logic                          st_valid,
  input  logic [ENTRIES-1:0]            st_hit,
  output logic [ENTRIES-1:0]            valid_q,
  output logic [ENTRIES-1:0][REG_W-1:0] reg_q,
  output logic [ENTRIES-1:0][TAG_W-1:0] tag_q
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic wr;
    assign wr = ins_valid && (ins_slot == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[g] <= 1'b0;
      end else if (wr) begin
        valid_q[g] <= 1'b1;
      end else if (st_valid && st_hit[g]) begin
        valid_q[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (wr) begin
        reg_q[g] <= ins_reg;
        tag_q[g] <= ins_tag;
      end
    end
  end

endmodule

// File: rtl/spec_load_tracker.sv
module spec_load_tracker
  import slt_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int REG_W    = 7,
  parameter int ADDR_W   = 32,
  parameter int GRAN_LOG2 = 3,
  localparam int TAG_W   = ADDR_W - GRAN_LOG2,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  input  logic [REG_W-1:0]  ins_reg,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  output logic              res_valid,
  output logic              res_ok
);

  logic [TAG_W-1:0]              ins_tag;
  logic [TAG_W-1:0]              st_tag;
  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0][REG_W-1:0] reg_q;
  logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
  logic [ENTRIES-1:0]            st_hit;
  logic [ENTRIES-1:0]            ins_hit;
  logic [ENTRIES-1:0]            chk_hit;
  logic [IDX_W-1:0]              slot;
  pick_e                         pick;

  assign ins_tag = ins_addr[ADDR_W-1:GRAN_LOG2];
  assign st_tag  = st_addr[ADDR_W-1:GRAN_LOG2];

  slt_match #(.ENTRIES(ENTRIES), .REG_W(REG_W), .TAG_W(TAG_W)) i_match (
    .valid_q (valid_q),
    .reg_q   (reg_q),
    .tag_q   (tag_q),
    .st_tag  (st_tag),
    .ins_reg (ins_reg),
    .chk_reg (chk_reg),
    .st_hit  (st_hit),
    .ins_hit (ins_hit),
    .chk_hit (chk_hit)
  );

  slt_victim #(.ENTRIES(ENTRIES)) i_victim (
    .clk       (clk),
    .rst       (rst),
    .ins_valid (ins_valid),
    .valid_q   (valid_q),
    .ins_hit   (ins_hit),
    .slot      (slot),
    .pick      (pick)
  );

  slt_array #(.ENTRIES(ENTRIES), .REG_W(REG_W), .TAG_W(TAG_W)) i_array (
    .clk       (clk),
    .rst       (rst),
    .ins_valid (ins_valid),
    .ins_slot  (slot),
    .ins_reg   (ins_reg),
    .ins_tag   (ins_tag),
    .st_valid  (st_valid),
    .st_hit    (st_hit),
    .valid_q   (valid_q),
    .reg_q     (reg_q),
    .tag_q     (tag_q)
  );

  // Registered result; lookup uses pre-update contents.
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_ok    <= 1'b0;
    end else begin
      res_valid <= chk_valid;
      res_ok    <= chk_valid && (|chk_hit);
    end
  end

endmodule

// File: rtl/slt_checks.sv
module slt_checks
  import slt_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               chk_valid,
  input logic               res_valid,
  input logic               res_ok,
  input logic               ins_valid,
  input logic               st_valid,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] st_hit,
  input logic [ENTRIES-1:0] ins_hit,
  input logic [ENTRIES-1:0] chk_hit,
  input logic [IDX_W-1:0]   slot
);

  p_res_timing_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (res_valid == $past(chk_valid)));

  p_ok_needs_req_r3: assert property (@(posedge clk) disable iff (rst)
    res_ok |-> res_valid);

  p_one_slot_per_reg_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chk_hit));

  p_store_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !ins_valid) |=> ((valid_q & $past(st_hit)) == '0));

  p_insert_lands_r10: assert property (@(posedge clk) disable iff (rst)
    ins_valid |=> valid_q[$past(slot)]);

  p_fill_grows_r7: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && !st_valid && !(|ins_hit) && !(&valid_q))
      |=> ($countones(valid_q) == $past($countones(valid_q)) + 1));

endmodule

bind spec_load_tracker slt_checks #(.ENTRIES(ENTRIES)) i_slt_checks (
  .clk       (clk),
  .rst       (rst),
  .chk_valid (chk_valid),
  .res_valid (res_valid),
  .res_ok    (res_ok),
  .ins_valid (ins_valid),
  .st_valid  (st_valid),
  .valid_q   (valid_q),
  .st_hit    (st_hit),
  .ins_hit   (ins_hit),
  .chk_hit   (chk_hit),
  .slot      (slot)
);

// File: tb/test_spec_load_tracker.sv
module test_spec_load_tracker;

  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ins_valid = 1'b0;
  logic [6:0]  ins_reg = '0;
  logic [31:0] ins_addr = '0;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic        chk_valid = 1'b0;
  logic [6:0]  chk_reg = '0;
  logic        res_valid;
  logic        res_ok;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  spec_load_tracker i_spec_load_tracker (
    .clk(clk), .rst(rst),
    .ins_valid(ins_valid), .ins_reg(ins_reg), .ins_addr(ins_addr),
    .st_valid(st_valid), .st_addr(st_addr),
    .chk_valid(chk_valid), .chk_reg(chk_reg),
    .res_valid(res_valid), .res_ok(res_ok)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog: run hung, cycle=%0d expected<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [31:0] addr_of(input int k);
    return 32'h1000 + 32'(k) * 32'd8;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_res(input bit exp_ok, input int r, input string req);
    checks++;
    if (!(res_valid === 1'b1 && res_ok === exp_ok)) begin
      failures++;
      $display("FAIL %s: reg %0d res_valid=%b res_ok=%b expected valid=1 ok=%b",
               req, r, res_valid, res_ok, exp_ok);
    end
  endtask

  task automatic do_ins(input int r, input logic [31:0] a);
    ins_valid = 1'b1; ins_reg = 7'(r); ins_addr = a;
    tick();
    ins_valid = 1'b0;
  endtask

  task automatic do_st(input logic [31:0] a);
    st_valid = 1'b1; st_addr = a;
    tick();
    st_valid = 1'b0;
  endtask

  task automatic do_chk(input int r, input bit exp_ok, input string req);
    chk_valid = 1'b1; chk_reg = 7'(r);
    tick();
    chk_valid = 1'b0;
    expect_res(exp_ok, r, req);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R1: reset state, idle cycle gives no result
    checks++;
    if (res_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1: res_valid=%b expected 0", res_valid);
    end
    for (int k = 0; k < N; k++) do_chk(k, 1'b0, "R1");
    tick();
    checks++;
    if (res_valid !== 1'b0) begin
      failures++;
      $display("FAIL R2: idle res_valid=%b expected 0", res_valid);
    end

    // R7: fill every slot with a distinct register; R2 all live
    for (int k = 0; k < N; k++) do_ins(k, addr_of(k));
    for (int k = 0; k < N; k++) do_chk(k, 1'b1, "R2");

    // R4: store inside reg 3's block (low bits differ) clears only reg 3
    do_st(addr_of(3) + 32'd5);
    do_st(32'h9000);
    for (int k = 0; k < N; k++) do_chk(k, k != 3, "R4");
    // R9: failed check creates nothing, repeated checks agree
    do_chk(3, 1'b0, "R9");
    do_chk(4, 1'b1, "R9");
    do_chk(4, 1'b1, "R9");

    // R12: freed slot 3 reused, no live entry evicted
    do_ins(20, 32'h2000);
    for (int k = 0; k < N; k++) if (k != 3) do_chk(k, 1'b1, "R12");
    do_chk(20, 1'b1, "R12");

    // R8: full table evicts slot 0, then slot 1
    do_ins(21, 32'h2100);
    do_chk(0, 1'b0, "R8");
    do_chk(1, 1'b1, "R8");
    do_chk(21, 1'b1, "R8");
    do_ins(22, 32'h2200);
    do_chk(1, 1'b0, "R8");
    do_chk(2, 1'b1, "R8");
    do_chk(22, 1'b1, "R8");

    // R6: overwrite reg 5 on a full table; old address untracked
    do_ins(5, 32'h3000);
    do_chk(2, 1'b1, "R6");
    do_st(addr_of(5));
    do_chk(5, 1'b1, "R6");
    do_st(32'h3000);
    do_chk(5, 1'b0, "R6");

    // R5: two registers in one block, one store clears both
    do_ins(30, 32'h4000);   // takes freed slot 5
    do_ins(31, 32'h4004);   // full: evicts slot 2 (reg 2)
    do_chk(2, 1'b0, "R8");
    do_chk(30, 1'b1, "R5");
    do_chk(31, 1'b1, "R5");
    do_st(32'h4000);
    do_chk(30, 1'b0, "R5");
    do_chk(31, 1'b0, "R5");
    do_chk(4, 1'b1, "R5");

    // R10: insert and store to the same block in one cycle
    ins_valid = 1'b1; ins_reg = 7'd40; ins_addr = 32'h5000;
    st_valid = 1'b1; st_addr = 32'h5003;
    tick();
    ins_valid = 1'b0; st_valid = 1'b0;
    do_chk(40, 1'b1, "R10");

    // R11: check alongside insert sees old contents
    ins_valid = 1'b1; ins_reg = 7'd41; ins_addr = 32'h6000;
    chk_valid = 1'b1; chk_reg = 7'd41;
    tick();
    ins_valid = 1'b0; chk_valid = 1'b0;
    expect_res(1'b0, 41, "R11");
    do_chk(41, 1'b1, "R11");
    // R11: check alongside store sees old contents
    st_valid = 1'b1; st_addr = 32'h6000;
    chk_valid = 1'b1; chk_reg = 7'd41;
    tick();
    st_valid = 1'b0; chk_valid = 1'b0;
    expect_res(1'b1, 41, "R11");
    do_chk(41, 1'b0, "R11");
    do_chk(41, 1'b0, "R9");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule